// File: doc/BRIEF.md
# Debug Session Trace Controller

This block runs one debug session at a time. Software arms it through a small control write port. The arm write starts a state sequencer and clears the trace store. While the session is armed and tracing is enabled, each capture strobe writes one data word into a 64-line circular buffer. Simple trigger inputs move the sequencer through its states. The current state is reported on a 3-bit flag field. A line count and a buffer-full flag show how much of the buffer holds data from the current session.

A session ends in one of three ways. Software can clear the arm bit, and the last state stays visible. An internal end event can fire. The sequencer can reach its final state. Either of the last two returns the sequencer to state 0. The full flag is cleared only by the power-on reset or by a new arm write. It survives an ordinary system reset, so the trace can still be inspected afterwards. While the secure input is high, tracing cannot be enabled and no capture takes place. The buffer can be read only while tracing is enabled.

Top module: `dbg_trace_ctrl`

## Requirements
- R1: While either reset is asserted, state_o reads 000, armed_o and trace_en_o read 0, and count_o reads 0 unless full_o is set. Power-on reset also clears full_o.
- R2: A control write with arm=1 while disarmed sets armed_o, forces state_o to 001 and clears full_o and the line count, all on the next clock edge. An arm=1 write while already armed changes nothing.
- R3: While armed, trig_adv_i steps the state 001 to 010 to 011 to 100 (final). trig_final_i jumps from any armed state straight to 100. trig_final_i has priority over trig_adv_i.
- R4: One cycle after the state reads 100, the state reads 000 and armed_o is 0. No line is captured while the state reads 100.
- R5: A control write with arm=0 while armed clears armed_o and leaves state_o at its last value.
- R6: end_evt_i while armed clears armed_o and sets state_o to 000 on the next edge. This takes priority over control writes and triggers.
- R7: A capture strobe that arrives while armed, with tracing enabled, secure low, end_evt_i low and the state not 100, stores cap_data_i at the write pointer. The pointer then advances modulo 64. The strobe in the cycle of a software disarm still stores its line.
- R8: full_o sets when the 64th line since the last arm is stored. count_o is 7 bits: it shows the stored line count 0..63 while full_o is 0 and reads 64 (bit 6 set) while full_o is 1.
- R9: A system reset (rst_ni low) leaves full_o unchanged and clears the write pointer. Only por_ni clears full_o.
- R10: The trace-enable bit loads from ctl_trace_i only on a control write made while disarmed and with secure_i low; otherwise it holds. With secure_i high no line is captured.
- R11: With trace-enable clear, rd_valid_o is 0 and rd_data_o is 0. With it set, rd_valid_o is 1 for address a when full_o is 1 or a is below the line count, and rd_data_o then returns the line stored at a.
- R12: state_o never shows the reserved codes 101, 110 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | System reset, active low, asynchronous; keeps the full flag |
| por_ni | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| secure_i | input | 1 | Secure mode: blocks trace enable and capture |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_arm_i | input | 1 | Arm bit value written |
| ctl_trace_i | input | 1 | Trace-enable bit value written |
| trig_adv_i | input | 1 | Advance sequencer to its next state |
| trig_final_i | input | 1 | Jump sequencer to the final state |
| end_evt_i | input | 1 | Internal end-of-session event |
| cap_stb_i | input | 1 | Capture strobe |
| cap_data_i | input | DATA_W | Word to capture |
| rd_addr_i | input | LINE_AW | Trace line read address |
| state_o | output | 3 | State flag field |
| armed_o | output | 1 | Session armed |
| trace_en_o | output | 1 | Trace-enable bit |
| full_o | output | 1 | Buffer full since last arm |
| count_o | output | LINE_AW+1 | Line count, top bit equals full_o |
| rd_data_o | output | DATA_W | Trace line read data |
| rd_valid_o | output | 1 | Read address holds a valid line |

## Verification
Sessions are closed in each of the three ways: software disarm after stepping through the states, an end event, and a final-trigger jump. Comparing the flag field after each close separates held-state behaviour from forced state 0. Capture runs are tried with a short burst, with a burst of more than 64 lines so that the pointer wraps and early lines are overwritten, and with the secure input high. These runs tell correct pointer arithmetic apart from off-by-one count and full-flag timing. A system reset is applied while the buffer is full, and a power-on reset afterwards, which shows whether the full flag is held to the right reset. Trace-enable writes are attempted while armed and while secure to confirm that both locks hold.

// File: rtl/dbg_trace_pkg.sv
package dbg_trace_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_S1    = 3'b001,
    ST_S2    = 3'b010,
    ST_S3    = 3'b011,
    ST_FINAL = 3'b100
  } seq_state_e;
endpackage

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_trace_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic       ctl_arm_i,
  input  logic       trig_adv_i,
  input  logic       trig_final_i,
  input  logic       end_evt_i,
  output logic       armed_o,
  output logic [2:0] state_o,
  output logic       arm_start_o,
  output logic       live_o
);
  seq_state_e state_q, state_d;
  logic       armed_q, armed_d;
  logic       int_stop, sw_stop, arm_start;

  always_comb begin
    arm_start = ctl_we_i & ctl_arm_i & ~armed_q;
    sw_stop   = ctl_we_i & ~ctl_arm_i & armed_q;
    int_stop  = armed_q & (end_evt_i | (state_q == ST_FINAL));
  end

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    if (int_stop) begin
      armed_d = 1'b0;
      state_d = ST_IDLE;
    end else if (arm_start) begin
      armed_d = 1'b1;
      state_d = ST_S1;
    end else if (sw_stop) begin
      armed_d = 1'b0;             // last state held
    end else if (armed_q) begin
      if (trig_final_i) state_d = ST_FINAL;
      else if (trig_adv_i) begin
        unique case (state_q)
          ST_S1:   state_d = ST_S2;
          ST_S2:   state_d = ST_S3;
          ST_S3:   state_d = ST_FINAL;
          default: state_d = state_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o     = armed_q;
  assign state_o     = state_q;
  assign arm_start_o = arm_start;
  assign live_o      = armed_q & ~end_evt_i & (state_q != ST_FINAL);

  p_arm_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ctl_arm_i && !armed_o) |=> (armed_o && state_o == 3'b001));
  p_final_ends_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'b100) |=> (state_o == 3'b000 && !armed_o));
  p_sw_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !end_evt_i && state_o != 3'b100 && ctl_we_i && !ctl_arm_i)
    |=> (!armed_o && state_o == $past(state_o)));
  p_evt_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && end_evt_i) |=> (state_o == 3'b000 && !armed_o));
  p_legal_code_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'b100);
  p_idle_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && !ctl_we_i) |=> $stable(state_o));
endmodule

// File: rtl/dbg_trace_buf.sv
module dbg_trace_buf #(
  parameter int DATA_W  = 16,
  parameter int LINE_AW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_ni,
  input  logic               clr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_en_i,
  input  logic [LINE_AW-1:0] rd_addr_i,
  output logic               full_o,
  output logic [LINE_AW:0]   count_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               rd_valid_o
);
  localparam int DEPTH = 1 << LINE_AW;
  localparam logic [LINE_AW-1:0] LAST = LINE_AW'(DEPTH - 1);

  logic [DATA_W-1:0]  mem_q [DEPTH];
  logic [LINE_AW-1:0] wptr_q;
  logic               full_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wptr_q <= '0;
    else if (clr_i)    wptr_q <= '0;
    else if (wr_en_i)  wptr_q <= wptr_q + 1'b1;
  end

  // full survives system reset, cleared only by power-on or re-arm
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                          full_q <= 1'b0;
    else if (clr_i)                       full_q <= 1'b0;
    else if (wr_en_i && wptr_q == LAST)   full_q <= 1'b1;
  end

  assign full_o     = full_q;
  assign count_o    = full_q ? {1'b1, {LINE_AW{1'b0}}} : {1'b0, wptr_q};
  assign rd_valid_o = rd_en_i & (full_q | (rd_addr_i < wptr_q));
  assign rd_data_o  = rd_valid_o ? mem_q[rd_addr_i] : '0;

  p_full_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i && count_o == (DEPTH - 1)) |=> full_o);
  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i && wptr_q == LAST) |=> (wptr_q == '0));
  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!full_o && count_o == '0));
  p_full_sticky_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    (full_o && !clr_i) |=> full_o);
endmodule

// File: rtl/dbg_trace_ctrl.sv
module dbg_trace_ctrl #(
  parameter int DATA_W  = 16,
  parameter int LINE_AW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_ni,
  input  logic               secure_i,
  input  logic               ctl_we_i,
  input  logic               ctl_arm_i,
  input  logic               ctl_trace_i,
  input  logic               trig_adv_i,
  input  logic               trig_final_i,
  input  logic               end_evt_i,
  input  logic               cap_stb_i,
  input  logic [DATA_W-1:0]  cap_data_i,
  input  logic [LINE_AW-1:0] rd_addr_i,
  output logic [2:0]         state_o,
  output logic               armed_o,
  output logic               trace_en_o,
  output logic               full_o,
  output logic [LINE_AW:0]   count_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               rd_valid_o
);
  logic sys_rst_n;
  logic arm_start, live, cap_we, trace_en_q;

  assign sys_rst_n = rst_ni & por_ni;

  dbg_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (sys_rst_n),
    .ctl_we_i     (ctl_we_i),
    .ctl_arm_i    (ctl_arm_i),
    .trig_adv_i   (trig_adv_i),
    .trig_final_i (trig_final_i),
    .end_evt_i    (end_evt_i),
    .armed_o      (armed_o),
    .state_o      (state_o),
    .arm_start_o  (arm_start),
    .live_o       (live)
  );

  // trace enable: writable only while disarmed and not secure
  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n)                              trace_en_q <= 1'b0;
    else if (ctl_we_i && !armed_o && !secure_i)  trace_en_q <= ctl_trace_i;
  end

  assign trace_en_o = trace_en_q;
  assign cap_we     = cap_stb_i & live & trace_en_q & ~secure_i;

  dbg_trace_buf #(.DATA_W(DATA_W), .LINE_AW(LINE_AW)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (sys_rst_n),
    .por_ni     (por_ni),
    .clr_i      (arm_start),
    .wr_en_i    (cap_we),
    .wr_data_i  (cap_data_i),
    .rd_en_i    (trace_en_q),
    .rd_addr_i  (rd_addr_i),
    .full_o     (full_o),
    .count_o    (count_o),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  p_trace_lock_r10: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    (armed_o || secure_i) |=> $stable(trace_en_o));
  p_secure_nocap_r10: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    (secure_i && !ctl_we_i) |=> $stable(count_o));
  p_rd_gate_r11: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    !trace_en_o |-> (!rd_valid_o && rd_data_o == '0));
  p_count_top_r8: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    count_o[LINE_AW] == full_o);
  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    $rose(sys_rst_n) |-> (state_o == 3'b000 && !armed_o && !trace_en_o));
endmodule

// File: tb/dbg_trace_ctrl_tb.sv
module dbg_trace_ctrl_tb;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, por_ni = 1'b0, secure_i = 1'b0;
  logic ctl_we_i = 1'b0, ctl_arm_i = 1'b0, ctl_trace_i = 1'b0;
  logic trig_adv_i = 1'b0, trig_final_i = 1'b0, end_evt_i = 1'b0;
  logic cap_stb_i = 1'b0;
  logic [DW-1:0] cap_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [2:0] state_o;
  logic armed_o, trace_en_o, full_o, rd_valid_o;
  logic [AW:0] count_o;
  logic [DW-1:0] rd_data_o;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dbg_trace_ctrl #(.DATA_W(DW), .LINE_AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .secure_i(secure_i),
    .ctl_we_i(ctl_we_i), .ctl_arm_i(ctl_arm_i), .ctl_trace_i(ctl_trace_i),
    .trig_adv_i(trig_adv_i), .trig_final_i(trig_final_i), .end_evt_i(end_evt_i),
    .cap_stb_i(cap_stb_i), .cap_data_i(cap_data_i), .rd_addr_i(rd_addr_i),
    .state_o(state_o), .armed_o(armed_o), .trace_en_o(trace_en_o),
    .full_o(full_o), .count_o(count_o), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  // behavioural reference
  int m_state = 0, m_ptr = 0;
  bit m_armed = 0, m_te = 0, m_full = 0;
  logic [DW-1:0] m_mem [DEPTH];

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit cap, was_armed;
    if (!por_ni) begin
      m_state = 0; m_armed = 0; m_te = 0; m_full = 0; m_ptr = 0;
    end else if (!rst_ni) begin
      m_state = 0; m_armed = 0; m_te = 0; m_ptr = 0;
    end else begin
      was_armed = m_armed;
      cap = m_armed && m_te && !secure_i && cap_stb_i && m_state != 4 && !end_evt_i;
      if (cap) begin
        m_mem[m_ptr] = cap_data_i;
        m_ptr = (m_ptr + 1) % DEPTH;
        if (m_ptr == 0) m_full = 1;
      end
      if (m_armed && (end_evt_i || m_state == 4)) begin
        m_armed = 0; m_state = 0;
      end else if (ctl_we_i && ctl_arm_i && !m_armed) begin
        m_armed = 1; m_state = 1; m_full = 0; m_ptr = 0;
      end else if (ctl_we_i && !ctl_arm_i && m_armed) begin
        m_armed = 0;
      end else if (m_armed) begin
        if (trig_final_i) m_state = 4;
        else if (trig_adv_i && m_state < 4) m_state = m_state + 1;
      end
      if (ctl_we_i && !was_armed && !secure_i) m_te = ctl_trace_i;
    end
    #1;
    begin
      bit v;
      v = m_te && (m_full || rd_addr_i < m_ptr);
      chk("R3 state", state_o, m_state);
      chk("R4 armed", armed_o, m_armed);
      chk("R10 trace_en", trace_en_o, m_te);
      chk("R8 full", full_o, m_full);
      chk("R8 count", count_o, m_full ? DEPTH : m_ptr);
      chk("R11 rd_valid", rd_valid_o, v);
      if (v) chk("R7 rd_data", rd_data_o, m_mem[rd_addr_i]);
      else   chk("R11 rd_zero", rd_data_o, 0);
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ctl_we_i = 0; trig_adv_i = 0; trig_final_i = 0; end_evt_i = 0; cap_stb_i = 0;
      rd_addr_i = rd_addr_i + 7;
    end
  endtask

  task automatic wr(bit arm, bit te);
    ctl_we_i = 1; ctl_arm_i = arm; ctl_trace_i = te; tick();
  endtask

  task automatic capture(int n, int seed);
    for (int i = 0; i < n; i++) begin
      cap_stb_i = 1; cap_data_i = DW'(seed * 97 + i * 1021 + 16'h5a3c);
      tick();
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 reset state", state_o, 0);
    chk("R1 reset full", full_o, 0);
    por_ni = 1; rst_ni = 1; tick(2);
    // trace enable blocked while secure
    secure_i = 1; wr(0, 1);
    chk("R10 secure lock", trace_en_o, 0);
    secure_i = 0; wr(0, 1);
    chk("R10 trace set", trace_en_o, 1);
    // arm, short burst, step, software disarm
    wr(1, 1);
    chk("R2 arm state", state_o, 1);
    capture(10, 1);
    chk("R7 count10", count_o, 10);
    trig_adv_i = 1; tick();
    chk("R3 s2", state_o, 2);
    trig_adv_i = 1; tick();
    chk("R3 s3", state_o, 3);
    wr(1, 0);
    chk("R10 armed lock", trace_en_o, 1);
    chk("R2 rearm no effect", count_o, 10);
    wr(0, 1);
    chk("R5 held state", state_o, 3);
    chk("R5 disarmed", armed_o, 0);
    tick(DEPTH);
    // long burst with wrap
    wr(1, 1);
    capture(70, 2);
    chk("R8 full", full_o, 1);
    chk("R8 count64", count_o, 64);
    tick(DEPTH);
    // system reset keeps full, power-on clears
    rst_ni = 0; tick(2); rst_ni = 1; tick();
    chk("R9 full kept", full_o, 1);
    chk("R9 state idle", state_o, 0);
    por_ni = 0; tick(2); por_ni = 1; tick();
    chk("R9 por clears", full_o, 0);
    // final trigger jump
    wr(0, 1); wr(1, 1);
    capture(3, 3);
    trig_final_i = 1; trig_adv_i = 1; cap_stb_i = 1; tick();
    chk("R3 final jump", state_o, 4);
    cap_stb_i = 1; tick();
    chk("R4 final ends", state_o, 0);
    chk("R4 no cap in final", count_o, 4);
    // end event, secure capture blocked
    wr(1, 1);
    secure_i = 1; capture(5, 4);
    chk("R10 secure nocap", count_o, 0);
    secure_i = 0; capture(4, 5);
    trig_adv_i = 1; tick();
    end_evt_i = 1; trig_adv_i = 1; ctl_we_i = 1; ctl_arm_i = 0; cap_stb_i = 1; tick();
    chk("R6 evt state", state_o, 0);
    chk("R6 evt armed", armed_o, 0);
    chk("R6 no cap", count_o, 4);
    // reads with trace disabled
    wr(0, 0);
    chk("R11 valid off", rd_valid_o, 0);
    tick(8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule